// File: doc/BRIEF.md
# Frequency-Synthesizer Serial Programming Controller

This block loads a frequency-synthesizer device over a three-wire serial link: a serial clock, a data line and a latch-enable strobe. The host hands it 21-bit latch contents on a valid/ready port. The block turns each one into a 24-bit frame with three leading zero bits and shifts it out as three back-to-back bytes, most significant bit first. Latch-enable is held low for the whole frame, and its rising edge tells the device to commit the word.

After reset the controller does not accept host words straight away. It first sends three fixed words, in a fixed order: the reference-divider word, then the feedback-divider word, then the initialization word. Only when the third one has completed does it raise `active` and open the host port. The serial clock is made from the system clock by a half-period divider parameter. Elaboration stops with an error if the resulting rate is above the 4 MHz limit.

Two side functions sit next to the serial path. A power-down request drives the device's chip-enable pin, but a change is held back until no frame is being shifted. The device's lock-detect level is passed through a two-stage synchronizer and a stability filter, and the result is reported as a status bit.

Top module: `synprog_ctrl`

## Requirements
- R1: While reset is asserted: `syn_le` = 1, `syn_sclk` = 0, `syn_ce` = 1, `active` = 0, `host_ready` = 0, `lock_status` = 0.
- R2: Each frame carries 24 bits, with bit 23 first down to bit 0. Bits 23..21 are zero and bits 20..0 are the latch word. Each bit is valid on `syn_sdata` at the rising edge of `syn_sclk`.
- R3: `syn_sclk` idles low. Each bit period is 2*HALF_DIV system clocks: HALF_DIV clocks low and then HALF_DIV clocks high. `syn_sdata` changes only while `syn_sclk` is low.
- R4: `syn_le` falls at the clock edge where the frame starts, together with the first bit. It rises HALF_DIV clocks after the last falling edge of `syn_sclk`.
- R5: Between frames, `syn_le` stays high for 2*HALF_DIV system clocks before the next frame can start. A frame therefore occupies 51*HALF_DIV clocks from start to idle.
- R6: After reset the block sends, with no host involvement, INIT_R_WORD, then INIT_N_WORD, then INIT_I_WORD. `host_ready` stays low until all three are done, and host words presented during that time are held off.
- R7: `active` rises at the edge where the third initialization frame returns to idle. It stays high until reset.
- R8: `host_ready` is high exactly when `active` is high and no frame is in progress. A host word is taken when `host_valid` and `host_ready` are both high, and its frame starts at that same edge.
- R9: `syn_ce` follows the inverse of `pwr_down` one clock later, except while a frame is being shifted (latch-enable low). During that time the change waits until latch-enable has risen.
- R10: `lock_status` takes a new `syn_lock` level only after the synchronized input has differed from `lock_status` for LOCK_FILT consecutive clocks. Shorter pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host offers a latch word |
| host_word | input | 21 | Latch word content |
| host_ready | output | 1 | Block will take a word this cycle |
| pwr_down | input | 1 | Request to power the device down |
| active | output | 1 | Initialization sequence completed |
| lock_status | output | 1 | Filtered lock-detect level |
| syn_sclk | output | 1 | Serial clock to device |
| syn_sdata | output | 1 | Serial data to device |
| syn_le | output | 1 | Latch-enable strobe to device |
| syn_ce | output | 1 | Chip-enable to device (low = power-down) |
| syn_lock | input | 1 | Lock-detect level from device |

## Verification
A wrong bit counter or wrong shift state shows at the ports within one bit period: either the data line disagrees with the expected bit at the rising serial-clock edge, or the latch-enable edge lands on a different cycle than the 51*HALF_DIV frame timeline predicts. A sequencer that skips or repeats an initialization word shows up as soon as the third frame ends. Either the captured frame contents are out of order, or `active` and `host_ready` rise on the wrong cycle. Any fault in the filter counter moves the `lock_status` edge away from the expected cycle, and a glitch shorter than LOCK_FILT would leak through to the status bit.

// File: rtl/synprog_pkg.sv
package synprog_pkg;
  localparam int LATCH_BITS = 21;
  localparam int FRAME_BITS = 24;
  localparam int PAD_BITS   = FRAME_BITS - LATCH_BITS;
  localparam int BIT_IDX_W  = $clog2(FRAME_BITS);

  typedef logic [LATCH_BITS-1:0] latch_word_t;
  typedef logic [FRAME_BITS-1:0] frame_t;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_HOLD  = 2'd2,
    SH_GAP   = 2'd3
  } sh_state_e;
endpackage

// File: rtl/synprog_shifter.sv
module synprog_shifter #(
  parameter int HALF_DIV = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  synprog_pkg::latch_word_t   word_i,
  output logic                       idle_o,
  output logic                       shifting_o,
  output logic                       done_o,
  output logic                       sclk_o,
  output logic                       sdata_o,
  output logic                       le_o
);
  import synprog_pkg::*;

  localparam int CW = $clog2(2*HALF_DIV + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(2*HALF_DIV - 1);
  localparam logic [BIT_IDX_W-1:0] TOP_BIT = BIT_IDX_W'(FRAME_BITS - 1);

  sh_state_e             st_q, st_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic [BIT_IDX_W-1:0]  bit_q, bit_d;
  frame_t                frm_q, frm_d;
  logic                  sclk_q, sclk_d;
  logic                  sdata_q, sdata_d;
  logic                  le_q, le_d;
  frame_t                frm_in;

  assign frm_in = {{PAD_BITS{1'b0}}, word_i};

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    frm_d   = frm_q;
    sclk_d  = sclk_q;
    sdata_d = sdata_q;
    le_d    = le_q;
    unique case (st_q)
      SH_IDLE: begin
        if (start_i) begin
          frm_d   = frm_in;
          sdata_d = frm_in[FRAME_BITS-1];
          le_d    = 1'b0;
          sclk_d  = 1'b0;
          cnt_d   = '0;
          bit_d   = TOP_BIT;
          st_d    = SH_SHIFT;
        end
      end
      SH_SHIFT: begin
        if (cnt_q == HALF_LAST) begin
          cnt_d = '0;
          if (!sclk_q) begin
            sclk_d = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (bit_q == '0) begin
              st_d = SH_HOLD;
            end else begin
              bit_d   = bit_q - 1'b1;
              sdata_d = frm_q[bit_q - 1'b1];
            end
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SH_HOLD: begin
        if (cnt_q == HALF_LAST) begin
          cnt_d = '0;
          le_d  = 1'b1;
          st_d  = SH_GAP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SH_GAP: begin
        if (cnt_q == GAP_LAST) begin
          cnt_d = '0;
          st_d  = SH_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SH_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      frm_q   <= '0;
      sclk_q  <= 1'b0;
      sdata_q <= 1'b0;
      le_q    <= 1'b1;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      frm_q   <= frm_d;
      sclk_q  <= sclk_d;
      sdata_q <= sdata_d;
      le_q    <= le_d;
    end
  end

  assign idle_o     = (st_q == SH_IDLE);
  assign shifting_o = (st_q == SH_SHIFT) || (st_q == SH_HOLD);
  assign done_o     = (st_q == SH_GAP) && (cnt_q == GAP_LAST);
  assign sclk_o     = sclk_q;
  assign sdata_o    = sdata_q;
  assign le_o       = le_q;

  // R3
  sdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_q) |-> !sclk_q);
  // R4
  sclk_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> !le_q);
  // R4
  le_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(le_q) |-> (!sclk_q && $past(!sclk_q)));
endmodule

// File: rtl/synprog_lock_filter.sv
module synprog_lock_filter #(
  parameter int LOCK_FILT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  output logic status_o
);
  localparam int CW = $clog2(LOCK_FILT + 1);
  localparam logic [CW-1:0] RUN_LAST = CW'(LOCK_FILT - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q, run_d;
  logic          stat_q, stat_d;
  logic          differs;

  assign differs = sync_q[1] != stat_q;

  always_comb begin
    run_d  = '0;
    stat_d = stat_q;
    if (differs) begin
      if (run_q == RUN_LAST) begin
        stat_d = sync_q[1];
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      run_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], lock_i};
      run_q  <= run_d;
      stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;

  // R10
  lock_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_q) |-> ($past(sync_q[1]) == stat_q));
endmodule

// File: rtl/synprog_init_seq.sv
module synprog_init_seq #(
  parameter synprog_pkg::latch_word_t INIT_R_WORD = '0,
  parameter synprog_pkg::latch_word_t INIT_N_WORD = '0,
  parameter synprog_pkg::latch_word_t INIT_I_WORD = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     idle_i,
  input  logic                     done_i,
  output logic                     start_o,
  output synprog_pkg::latch_word_t word_o,
  output logic                     active_o
);
  localparam int STEPS = 3;
  localparam logic [1:0] LAST_STEP = 2'(STEPS - 1);

  logic [1:0] step_q, step_d;
  logic       act_q, act_d;

  always_comb begin
    step_d = step_q;
    act_d  = act_q;
    if (done_i && !act_q) begin
      if (step_q == LAST_STEP) act_d  = 1'b1;
      else                     step_d = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      act_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      act_q  <= act_d;
    end
  end

  always_comb begin
    unique case (step_q)
      2'd0:    word_o = INIT_R_WORD;
      2'd1:    word_o = INIT_N_WORD;
      default: word_o = INIT_I_WORD;
    endcase
  end

  assign start_o  = idle_i && !act_q;
  assign active_o = act_q;

  // R7
  active_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |=> act_q);
  // R6
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != $past(step_q)) |-> (step_q == $past(step_q) + 2'd1));
endmodule

// File: rtl/synprog_ctrl.sv
module synprog_ctrl #(
  parameter int                       CLK_HZ      = 50_000_000,
  parameter int                       MAX_SCLK_HZ = 4_000_000,
  parameter int                       HALF_DIV    = 7,
  parameter int                       LOCK_FILT   = 8,
  parameter synprog_pkg::latch_word_t INIT_R_WORD = 21'h0000A1,
  parameter synprog_pkg::latch_word_t INIT_N_WORD = 21'h003202,
  parameter synprog_pkg::latch_word_t INIT_I_WORD = 21'h000093
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  input  logic [20:0] host_word,
  output logic        host_ready,
  input  logic        pwr_down,
  output logic        active,
  output logic        lock_status,
  output logic        syn_sclk,
  output logic        syn_sdata,
  output logic        syn_le,
  output logic        syn_ce,
  input  logic        syn_lock
);
  import synprog_pkg::*;

  localparam longint SCLK_HZ_X = longint'(CLK_HZ);
  localparam longint SCLK_LIM  = longint'(MAX_SCLK_HZ) * 2 * longint'(HALF_DIV);

  generate
    if (HALF_DIV < 1 || SCLK_HZ_X > SCLK_LIM) begin : g_rate_bad
      $error("serial clock rate above limit: raise HALF_DIV");
    end
  endgenerate

  logic        sh_idle, sh_shifting, sh_done, sh_start;
  logic        init_start, act;
  latch_word_t init_word, tx_word;
  logic        ce_q, ce_d;

  synprog_init_seq #(
    .INIT_R_WORD (INIT_R_WORD),
    .INIT_N_WORD (INIT_N_WORD),
    .INIT_I_WORD (INIT_I_WORD)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle_i   (sh_idle),
    .done_i   (sh_done),
    .start_o  (init_start),
    .word_o   (init_word),
    .active_o (act)
  );

  assign host_ready = act && sh_idle;
  assign sh_start   = init_start || (host_valid && host_ready);
  assign tx_word    = act ? host_word : init_word;

  synprog_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (sh_start),
    .word_i     (tx_word),
    .idle_o     (sh_idle),
    .shifting_o (sh_shifting),
    .done_o     (sh_done),
    .sclk_o     (syn_sclk),
    .sdata_o    (syn_sdata),
    .le_o       (syn_le)
  );

  synprog_lock_filter #(.LOCK_FILT(LOCK_FILT)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_i   (syn_lock),
    .status_o (lock_status)
  );

  always_comb begin
    ce_d = ce_q;
    if (!sh_shifting) ce_d = !pwr_down;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b1;
    else        ce_q <= ce_d;
  end

  assign syn_ce = ce_q;
  assign active = act;

  // R6
  ready_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> active);
  // R9
  ce_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(syn_ce) |-> $past(syn_le));
  // R8
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!syn_le && !$past(syn_le)) |-> !host_ready);
endmodule

// File: tb/test_synprog_ctrl.sv
module test_synprog_ctrl;
  localparam int H  = 7;
  localparam int LF = 8;
  localparam logic [20:0] WR = 21'h15A5C3;
  localparam logic [20:0] WN = 21'h0C0381;
  localparam logic [20:0] WI = 21'h1000E7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_valid = 1'b0;
  logic [20:0] host_word = '0;
  logic pwr_down = 1'b0;
  logic syn_lock = 1'b0;
  logic host_ready, active, lock_status, syn_sclk, syn_sdata, syn_le, syn_ce;

  always #10 clk = ~clk;

  synprog_ctrl #(
    .HALF_DIV(H), .LOCK_FILT(LF),
    .INIT_R_WORD(WR), .INIT_N_WORD(WN), .INIT_I_WORD(WI)
  ) i_synprog_ctrl (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_word(host_word),
    .host_ready(host_ready), .pwr_down(pwr_down), .active(active),
    .lock_status(lock_status), .syn_sclk(syn_sclk), .syn_sdata(syn_sdata),
    .syn_le(syn_le), .syn_ce(syn_ce), .syn_lock(syn_lock)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  function automatic logic [20:0] init_word(int k);
    if (k == 0) return WR;
    if (k == 1) return WN;
    return WI;
  endfunction

  // behavioural reference
  int mt = -1;
  int m_init = 0;
  bit m_active = 0;
  bit m_ce = 1;
  logic [23:0] m_w = '0;
  logic [20:0] hq[$];
  logic [23:0] fq[$];
  bit ls1 = 0, ls2 = 0, lstat = 0;
  int lrun = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mt = -1; m_init = 0; m_active = 0; m_ce = 1;
      ls1 = 0; ls2 = 0; lstat = 0; lrun = 0;
    end else begin
      if (!(mt >= 0 && mt < 49*H)) m_ce = !pwr_down;
      if (mt >= 0) begin
        mt++;
        if (mt == 51*H) begin
          mt = -1;
          if (!m_active) begin
            m_init++;
            if (m_init == 3) m_active = 1;
          end
        end
      end else if (!m_active) begin
        m_w = {3'b000, init_word(m_init)};
        fq.push_back(m_w);
        mt = 0;
      end else if (host_valid) begin
        m_w = {3'b000, hq.pop_front()};
        fq.push_back(m_w);
        mt = 0;
      end
      if (ls2 == lstat) lrun = 0;
      else begin
        lrun++;
        if (lrun == LF) begin lstat = ls2; lrun = 0; end
      end
      ls2 = ls1;
      ls1 = syn_lock;
    end
  end

  // host driver
  always @(negedge clk) begin
    host_valid = (hq.size() != 0);
    host_word  = (hq.size() != 0) ? hq[0] : '0;
  end

  // per-cycle comparison and frame capture
  logic prev_sclk = 1'b0, prev_le = 1'b1, prev_act = 1'b0;
  logic [23:0] cap = '0;
  int nb = 0;
  int frames = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk((mt >= 49*H || mt < 0) ? "R5" : "R4", "syn_le", syn_le,
          (mt < 0 || mt >= 49*H) ? 1 : 0);
      chk("R3", "syn_sclk", syn_sclk,
          (mt >= 0 && mt < 48*H && ((mt / H) % 2 == 1)) ? 1 : 0);
      if (mt >= 0 && mt < 48*H)
        chk("R2", "syn_sdata", syn_sdata, m_w[23 - mt/(2*H)]);
      chk("R7", "active", active, m_active);
      chk(m_active ? "R8" : "R6", "host_ready", host_ready, (m_active && mt < 0) ? 1 : 0);
      chk("R9", "syn_ce", syn_ce, m_ce);
      chk("R10", "lock_status", lock_status, lstat);

      if (!syn_le && prev_le) begin cap = '0; nb = 0; end
      if (syn_sclk && !prev_sclk) begin cap = {cap[22:0], syn_sdata}; nb++; end
      if (syn_le && !prev_le) begin
        chk("R2", "frame bit count", nb, 24);
        if (fq.size() == 0) chk("R2", "unexpected frame", cap, 32'hFFFF_FFFF);
        else chk("R2", "frame content", cap, fq.pop_front());
        frames++;
      end
      // R7: active rises right after the third init frame
      if (active && !prev_act) chk("R7", "frames before active", frames, 3);
      prev_sclk = syn_sclk;
      prev_le   = syn_le;
      prev_act  = active;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "syn_le", syn_le, 1);
    chk("R1", "syn_sclk", syn_sclk, 0);
    chk("R1", "syn_ce", syn_ce, 1);
    chk("R1", "active", active, 0);
    chk("R1", "host_ready", host_ready, 0);
    chk("R1", "lock_status", lock_status, 0);
    rst_n = 1'b1;
    // R6: words queued during init must wait
    hq.push_back(21'h1ABCDE);
    hq.push_back(21'h000001);
    // R10: short glitch, then a long high level, then a short low dip
    repeat (20) @(negedge clk);
    syn_lock = 1'b1;
    repeat (3) @(negedge clk);
    syn_lock = 1'b0;
    repeat (30) @(negedge clk);
    syn_lock = 1'b1;
    repeat (40) @(negedge clk);
    syn_lock = 1'b0;
    repeat (5) @(negedge clk);
    syn_lock = 1'b1;
    repeat (LF) @(negedge clk);
    syn_lock = 1'b0;
    repeat (LF + 4) @(negedge clk);
    while (!m_active) @(negedge clk);
    // R9: request power-down in the middle of a host frame
    repeat (100) @(negedge clk);
    pwr_down = 1'b1;
    repeat (420) @(negedge clk);
    pwr_down = 1'b0;
    // R8: back-to-back host words with edge patterns
    hq.push_back(21'h1FFFFF);
    hq.push_back(21'h155555);
    hq.push_back(21'h0AAAAA);
    while (hq.size() != 0 || mt >= 0) @(negedge clk);
    pwr_down = 1'b1;
    repeat (5) @(negedge clk);
    pwr_down = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2", "frames pending", fq.size(), 0);
    chk("R8", "frames sent", frames, 8);
    summary();
  end
endmodule